// File: doc/BRIEF.md
# Switch Bring-up Sequencer with Microcode Loader

This block runs on the host side of a managed Ethernet switch and brings it to an operational state without software help. It works through a register-access port: it presents one read or write at a time (block, subblock, register, data) and waits for an acknowledge from an external SPI master, which carries the access to the switch and returns read data or an error flag. The microcode image comes from a local ROM, which is read combinationally through a byte address.

After a start pulse the sequencer probes the device, optionally pulses the device's hardware reset, confirms the device identity, halts the embedded processor, streams the microcode into the device's program memory, reads it all back and compares it, releases the processor, and finally programs and checks the clock-delay, port-mode and MAC configuration registers. It ends in a sticky "done" state or in a sticky "fail" state that carries a cause code; only reset leaves either of them.

Top module: `switch_bringup_seq`

## Requirements
- R1: During and after reset, `busy`, `done`, `fail`, `chip_rst` and `acc_req` are low and `err_code` is 0; nothing happens until `start` is pulsed in the idle state.
- R2: The first access is a read of block 7, subblock 0, register 0x15. If it returns 0xFFFFFFFF, `chip_rst` goes high for exactly RST_CYCLES cycles before the next access; otherwise `chip_rst` stays low.
- R3: The second access reads block 7, subblock 0, register 0x18. Unless read bits [27:12] equal 0x7385 the sequencer fails with code 1 (no device) and issues no further access.
- R4: The processor is halted by writing 0x0000008C to block 7 register 0x10, followed by a write of 0 to the program-address register (block 7 register 0x11).
- R5: Every ROM byte, from address 0 upward, is written to block 7 register 0x12 with the byte in data bits [7:0] and zeros above.
- R6: After the upload the program-address register is written with 0 again and the bytes are read back from register 0x12 in order; a read value above 0xFF fails at once with code 3.
- R7: Read-back mismatches are counted; reading stops at the fifth mismatch, and any nonzero count fails with code 3 (verify error).
- R8: After a clean verify the processor is started by writing 0x0000010B to block 7 register 0x10.
- R9: Configuration writes 0x33 to block 7 register 0x05 and reads it back (read AND 0x33 must equal 0x33), then writes 0x2C to block 1, subblock 6, register 0x19 and reads it back (bits [7:0] must equal 0x2C); a failed check gives code 4.
- R10: The MAC configuration register (block 1, subblock 6, register 0x00) is written with 0x20000030 and then 0x10070184, after which `done` rises.
- R11: An access returning `acc_err` fails with the phase code: 1 during probe/identity, 2 during halt, upload or processor start, 3 during read-back, 4 during configuration. `fail` and `err_code` hold until reset, and no access follows.
- R12: Once raised, `acc_req` and the access fields stay steady until `acc_ack`; `acc_req` drops in the cycle after acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin the bring-up (honoured only when idle) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence completed (sticky) |
| fail | output | 1 | Sequence aborted (sticky) |
| err_code | output | 3 | 0 none, 1 no device, 2 upload, 3 verify, 4 configuration |
| chip_rst | output | 1 | Hardware reset pulse toward the device |
| rom_addr | output | ROM_AW | Microcode ROM byte address |
| rom_data | input | 8 | Microcode byte at `rom_addr` (combinational) |
| acc_req | output | 1 | Access request |
| acc_write | output | 1 | 1 write, 0 read |
| acc_block | output | 3 | Target block |
| acc_sub | output | 4 | Target subblock |
| acc_reg | output | 8 | Target register |
| acc_wdata | output | 32 | Write data (0 on reads) |
| acc_ack | input | 1 | Access complete |
| acc_err | input | 1 | Access failed (valid with `acc_ack`) |
| acc_rdata | input | 32 | Read data (valid with `acc_ack`) |

## Verification
A response acknowledged at one edge is registered at that edge, acted on at the next, and the following request appears at the edge after that, so requests come two cycles after each acknowledge and `done`/`fail` settle two cycles after the last one. The bench's scoreboard compares each request against its queue on the first falling edge where `acc_req` is seen high, which is after every register on the way has settled. Final status is sampled only after the sequence has been idle for many cycles, and the reset pulse width is counted on falling edges up to the moment the identity read appears.

// File: rtl/bringup_pkg.sv
// Shared types and constants for the switch bring-up sequencer.
// Assumes a register address of block (3 bits), subblock (4 bits), register (8 bits).
package bringup_pkg;

    typedef enum logic [4:0] {
        S_IDLE, S_MBOX, S_PULSE, S_ID, S_HALT, S_PTR0, S_LOAD, S_PTR1,
        S_CHECK, S_RUN, S_DLY_W, S_DLY_R, S_PM_W, S_PM_R, S_MAC_RST,
        S_MAC_CFG, S_DONE, S_FAIL
    } seq_state_t;

    typedef enum logic [2:0] {
        F_NONE   = 3'd0,
        F_NODEV  = 3'd1,
        F_UPLOAD = 3'd2,
        F_VERIFY = 3'd3,
        F_CONFIG = 3'd4
    } fault_t;

    typedef struct packed {
        logic        wr;
        logic [2:0]  blk;
        logic [3:0]  sub;
        logic [7:0]  addr;
        logic [31:0] data;
    } acc_cmd_t;

    localparam logic [2:0]  BLK_SYS      = 3'd7;
    localparam logic [2:0]  BLK_MAC      = 3'd1;
    localparam logic [3:0]  SUB_HOSTMAC  = 4'd6;
    localparam logic [7:0]  RG_MAILBOX   = 8'h15;
    localparam logic [7:0]  RG_IDENT     = 8'h18;
    localparam logic [7:0]  RG_CPUCTL    = 8'h10;
    localparam logic [7:0]  RG_PGMPTR    = 8'h11;
    localparam logic [7:0]  RG_PGMWIN    = 8'h12;
    localparam logic [7:0]  RG_CLKDLY    = 8'h05;
    localparam logic [7:0]  RG_PORTMODE  = 8'h19;
    localparam logic [7:0]  RG_MACCFG    = 8'h00;

    localparam logic [15:0] IDENT_MATCH  = 16'h7385;
    localparam logic [31:0] CPU_HALT     = 32'h0000_008C;
    localparam logic [31:0] CPU_RUN      = 32'h0000_010B;
    localparam logic [31:0] CLKDLY_VAL   = 32'h0000_0033;
    localparam logic [31:0] PORTMODE_VAL = 32'h0000_002C;
    localparam logic [31:0] MAC_HOLD     = 32'h2000_0030;
    localparam logic [31:0] MAC_RUN      = 32'h1007_0184;

endpackage

// File: rtl/reg_access_port.sv
// Request/acknowledge access port toward the external SPI master.
// Latches one command per issue pulse, holds it until acknowledge, then
// presents the response for exactly one cycle. Assumes issue only while idle.
module reg_access_port
    import bringup_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        issue,
    input  acc_cmd_t    cmd,
    input  logic        acc_ack,
    input  logic        acc_err,
    input  logic [31:0] acc_rdata,
    output logic        acc_req,
    output acc_cmd_t    cmd_q,
    output logic        rsp_valid,
    output logic        rsp_err,
    output logic [31:0] rsp_data
);

    // Hold the request until acknowledged and register the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_req   <= 1'b0;
            cmd_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (issue && !acc_req) begin
                acc_req <= 1'b1;
                cmd_q   <= cmd;
            end else if (acc_req && acc_ack) begin
                acc_req   <= 1'b0;
                rsp_valid <= 1'b1;
                rsp_err   <= acc_err;
                rsp_data  <= acc_rdata;
            end
        end
    end

endmodule

// File: rtl/mismatch_tally.sv
// Counts read-back mismatches during verification.
// at_limit flags that LIMIT mismatches are already recorded, so one more ends the check.
module mismatch_tally #(
    parameter  int LIMIT = 4,
    localparam int CW    = $clog2(LIMIT + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic hit,
    output logic any_seen,
    output logic at_limit
);

    logic [CW-1:0] cnt;

    // Clear at the start of a verify pass, count each mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (clear) cnt <= '0;
        else if (hit)   cnt <= cnt + 1'b1;
    end

    assign any_seen = (cnt != '0);
    assign at_limit = (cnt == CW'(LIMIT));

endmodule

// File: rtl/rst_pulse_gen.sv
// Generates a hardware reset pulse of exactly CYCLES clock cycles.
// Assumes fire is not repeated while a pulse is running.
module rst_pulse_gen #(
    parameter  int CYCLES = 16,
    localparam int CW     = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse,
    output logic last
);

    logic [CW-1:0] cnt;

    // Load the width on fire, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (fire)        cnt <= CW'(CYCLES);
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign pulse = (cnt != '0);
    assign last  = (cnt == CW'(1));

endmodule

// File: rtl/switch_bringup_seq.sv
// Top-level bring-up sequencer: probe, optional device reset, identity check,
// processor halt, microcode upload, read-back verify, processor start and
// checked configuration. Assumes a combinational microcode ROM on rom_addr/rom_data
// and an SPI master that completes each access with acc_ack (+acc_err, acc_rdata).
module switch_bringup_seq
    import bringup_pkg::*;
#(
    parameter  int UCODE_LEN      = 256,
    parameter  int RST_CYCLES     = 16,
    parameter  int MISMATCH_LIMIT = 4,
    localparam int ROM_AW         = (UCODE_LEN > 1) ? $clog2(UCODE_LEN) : 1,
    localparam int IW             = $clog2(UCODE_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [2:0]        err_code,
    output logic              chip_rst,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [7:0]        rom_data,
    output logic              acc_req,
    output logic              acc_write,
    output logic [2:0]        acc_block,
    output logic [3:0]        acc_sub,
    output logic [7:0]        acc_reg,
    output logic [31:0]       acc_wdata,
    input  logic              acc_ack,
    input  logic              acc_err,
    input  logic [31:0]       acc_rdata
);

    seq_state_t    state;
    fault_t        fault;
    logic          sent;
    logic [IW-1:0] idx;
    acc_cmd_t      cmd, cmd_q;
    logic          is_acc, issue;
    logic          rsp_valid, rsp_err;
    logic [31:0]   rsp_data;
    logic          pulse_fire, pulse_last;
    logic          tally_any, tally_full, tally_clear, tally_hit;
    logic          last_byte, big_val, byte_bad;

    reg_access_port u_port (
        .clk(clk), .rst_n(rst_n), .issue(issue), .cmd(cmd),
        .acc_ack(acc_ack), .acc_err(acc_err), .acc_rdata(acc_rdata),
        .acc_req(acc_req), .cmd_q(cmd_q),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data)
    );

    rst_pulse_gen #(.CYCLES(RST_CYCLES)) u_pulse (
        .clk(clk), .rst_n(rst_n), .fire(pulse_fire),
        .pulse(chip_rst), .last(pulse_last)
    );

    mismatch_tally #(.LIMIT(MISMATCH_LIMIT)) u_tally (
        .clk(clk), .rst_n(rst_n), .clear(tally_clear), .hit(tally_hit),
        .any_seen(tally_any), .at_limit(tally_full)
    );

    // Select the access belonging to the current step.
    always_comb begin
        cmd    = '0;
        is_acc = 1'b1;
        case (state)
            S_MBOX:    cmd = '{1'b0, BLK_SYS, 4'd0, RG_MAILBOX, 32'd0};
            S_ID:      cmd = '{1'b0, BLK_SYS, 4'd0, RG_IDENT,   32'd0};
            S_HALT:    cmd = '{1'b1, BLK_SYS, 4'd0, RG_CPUCTL,  CPU_HALT};
            S_PTR0,
            S_PTR1:    cmd = '{1'b1, BLK_SYS, 4'd0, RG_PGMPTR,  32'd0};
            S_LOAD:    cmd = '{1'b1, BLK_SYS, 4'd0, RG_PGMWIN,  {24'd0, rom_data}};
            S_CHECK:   cmd = '{1'b0, BLK_SYS, 4'd0, RG_PGMWIN,  32'd0};
            S_RUN:     cmd = '{1'b1, BLK_SYS, 4'd0, RG_CPUCTL,  CPU_RUN};
            S_DLY_W:   cmd = '{1'b1, BLK_SYS, 4'd0, RG_CLKDLY,  CLKDLY_VAL};
            S_DLY_R:   cmd = '{1'b0, BLK_SYS, 4'd0, RG_CLKDLY,  32'd0};
            S_PM_W:    cmd = '{1'b1, BLK_MAC, SUB_HOSTMAC, RG_PORTMODE, PORTMODE_VAL};
            S_PM_R:    cmd = '{1'b0, BLK_MAC, SUB_HOSTMAC, RG_PORTMODE, 32'd0};
            S_MAC_RST: cmd = '{1'b1, BLK_MAC, SUB_HOSTMAC, RG_MACCFG,   MAC_HOLD};
            S_MAC_CFG: cmd = '{1'b1, BLK_MAC, SUB_HOSTMAC, RG_MACCFG,   MAC_RUN};
            default:   is_acc = 1'b0;
        endcase
    end

    assign issue       = is_acc && !sent;
    assign last_byte   = (idx == IW'(UCODE_LEN - 1));
    assign big_val     = (rsp_data[31:8] != '0);
    assign byte_bad    = (rsp_data[7:0] != rom_data);
    assign tally_hit   = (state == S_CHECK) && rsp_valid && !rsp_err && !big_val && byte_bad;
    assign tally_clear = (state == S_PTR1);
    assign pulse_fire  = (state == S_MBOX) && rsp_valid && !rsp_err && (&rsp_data);

    // Step through the bring-up sequence; faults end in a sticky state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            fault <= F_NONE;
            sent  <= 1'b0;
            idx   <= '0;
        end else begin
            if (rsp_valid)  sent <= 1'b0;
            else if (issue) sent <= 1'b1;
            case (state)
                S_IDLE: if (start) state <= S_MBOX;
                S_MBOX: if (rsp_valid) begin
                    if (rsp_err)         begin state <= S_FAIL; fault <= F_NODEV; end
                    else if (&rsp_data)  state <= S_PULSE;
                    else                 state <= S_ID;
                end
                S_PULSE: if (pulse_last) state <= S_ID;
                S_ID: if (rsp_valid) begin
                    if (rsp_err || rsp_data[27:12] != IDENT_MATCH) begin
                        state <= S_FAIL; fault <= F_NODEV;
                    end else state <= S_HALT;
                end
                S_HALT: if (rsp_valid) begin
                    if (rsp_err) begin state <= S_FAIL; fault <= F_UPLOAD; end
                    else state <= S_PTR0;
                end
                S_PTR0: if (rsp_valid) begin
                    idx <= '0;
                    if (rsp_err) begin state <= S_FAIL; fault <= F_UPLOAD; end
                    else state <= S_LOAD;
                end
                S_LOAD: if (rsp_valid) begin
                    if (rsp_err)        begin state <= S_FAIL; fault <= F_UPLOAD; end
                    else if (last_byte) begin state <= S_PTR1; idx <= '0; end
                    else                idx <= idx + 1'b1;
                end
                S_PTR1: if (rsp_valid) begin
                    if (rsp_err) begin state <= S_FAIL; fault <= F_UPLOAD; end
                    else state <= S_CHECK;
                end
                S_CHECK: if (rsp_valid) begin
                    if (rsp_err || big_val || (byte_bad && tally_full)) begin
                        state <= S_FAIL; fault <= F_VERIFY;
                    end else if (last_byte) begin
                        if (tally_any || byte_bad) begin state <= S_FAIL; fault <= F_VERIFY; end
                        else state <= S_RUN;
                    end else idx <= idx + 1'b1;
                end
                S_RUN: if (rsp_valid) begin
                    if (rsp_err) begin state <= S_FAIL; fault <= F_UPLOAD; end
                    else state <= S_DLY_W;
                end
                S_DLY_W: if (rsp_valid) begin
                    if (rsp_err) begin state <= S_FAIL; fault <= F_CONFIG; end
                    else state <= S_DLY_R;
                end
                S_DLY_R: if (rsp_valid) begin
                    if (rsp_err || (rsp_data & CLKDLY_VAL) != CLKDLY_VAL) begin
                        state <= S_FAIL; fault <= F_CONFIG;
                    end else state <= S_PM_W;
                end
                S_PM_W: if (rsp_valid) begin
                    if (rsp_err) begin state <= S_FAIL; fault <= F_CONFIG; end
                    else state <= S_PM_R;
                end
                S_PM_R: if (rsp_valid) begin
                    if (rsp_err || rsp_data[7:0] != PORTMODE_VAL[7:0]) begin
                        state <= S_FAIL; fault <= F_CONFIG;
                    end else state <= S_MAC_RST;
                end
                S_MAC_RST: if (rsp_valid) begin
                    if (rsp_err) begin state <= S_FAIL; fault <= F_CONFIG; end
                    else state <= S_MAC_CFG;
                end
                S_MAC_CFG: if (rsp_valid) begin
                    if (rsp_err) begin state <= S_FAIL; fault <= F_CONFIG; end
                    else state <= S_DONE;
                end
                default: ;
            endcase
        end
    end

    assign busy      = !(state inside {S_IDLE, S_DONE, S_FAIL});
    assign done      = (state == S_DONE);
    assign fail      = (state == S_FAIL);
    assign err_code  = fault;
    assign rom_addr  = idx[ROM_AW-1:0];
    assign acc_write = cmd_q.wr;
    assign acc_block = cmd_q.blk;
    assign acc_sub   = cmd_q.sub;
    assign acc_reg   = cmd_q.addr;
    assign acc_wdata = cmd_q.data;

endmodule

// File: rtl/bringup_checker.sv
// Temporal checks on the bring-up sequencer's ports, bound to the top module.
module bringup_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        fail,
    input logic [2:0]  err_code,
    input logic        chip_rst,
    input logic        acc_req,
    input logic        acc_ack,
    input logic        acc_write,
    input logic [2:0]  acc_block,
    input logic [3:0]  acc_sub,
    input logic [7:0]  acc_reg,
    input logic [31:0] acc_wdata
);

    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !acc_ack) |=> (acc_req && $stable(acc_write) && $stable(acc_block)
                                   && $stable(acc_sub) && $stable(acc_reg) && $stable(acc_wdata)));

    p_req_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_ack) |=> !acc_req);

    p_fail_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> (fail && $stable(err_code)));

    p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    p_code_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (err_code != 3'd0));

    p_code_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !fail |-> (err_code == 3'd0));

    p_quiet_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail) |-> !acc_req);

    p_pulse_alone_r2: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst |-> (busy && !acc_req));

    p_status_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({busy, done, fail}) <= 1);

endmodule

bind switch_bringup_seq bringup_checker u_bringup_checker (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fail(fail),
    .err_code(err_code), .chip_rst(chip_rst), .acc_req(acc_req), .acc_ack(acc_ack),
    .acc_write(acc_write), .acc_block(acc_block), .acc_sub(acc_sub),
    .acc_reg(acc_reg), .acc_wdata(acc_wdata)
);

// File: tb/test_switch_bringup_seq.sv
`timescale 1ns/1ps
// Scoreboard bench: expected accesses are queued per case, a negedge monitor
// compares each new request and a device model answers it.
module test_switch_bringup_seq;

    localparam int LEN  = 16;
    localparam int RSTC = 5;
    localparam int AW   = $clog2(LEN);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          busy, done, fail, chip_rst;
    logic [2:0]    err_code;
    logic [AW-1:0] rom_addr;
    logic [7:0]    rom_data;
    logic          acc_req, acc_write;
    logic [2:0]    acc_block;
    logic [3:0]    acc_sub;
    logic [7:0]    acc_reg;
    logic [31:0]   acc_wdata;
    logic          acc_ack = 1'b0;
    logic          acc_err = 1'b0;
    logic [31:0]   acc_rdata = '0;

    always #4 clk = ~clk;

    switch_bringup_seq #(.UCODE_LEN(LEN), .RST_CYCLES(RSTC)) i_switch_bringup_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .fail(fail), .err_code(err_code), .chip_rst(chip_rst),
        .rom_addr(rom_addr), .rom_data(rom_data),
        .acc_req(acc_req), .acc_write(acc_write), .acc_block(acc_block),
        .acc_sub(acc_sub), .acc_reg(acc_reg), .acc_wdata(acc_wdata),
        .acc_ack(acc_ack), .acc_err(acc_err), .acc_rdata(acc_rdata)
    );

    function automatic logic [7:0] ucode(int a);
        return 8'((a * 29 + 7) ^ (a >> 1));
    endfunction
    assign rom_data = ucode(int'(rom_addr));

    typedef struct { string tag; logic [47:0] acc; } exp_t;
    exp_t exp_q[$];

    int n_tests = 0, n_fail = 0;
    // device model configuration
    logic [31:0] mbox_val, ident_val;
    logic [15:0] corrupt;
    int big_idx, err_on;
    bit cfg_bad;
    // device model and monitor state
    logic [7:0]  sram [0:255];
    logic [31:0] dly_reg, pm_reg;
    int ptr, lat, acc_n, rst_hi, rst_at_id, extra;
    bit prev_req;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic push(string tag, bit wr, int blk, int sub, int rg, logic [31:0] d);
        exp_t e;
        e.tag = tag;
        e.acc = {wr, 3'(blk), 4'(sub), 8'(rg), d};
        exp_q.push_back(e);
    endtask

    task automatic respond();
        logic [31:0] v;
        v = '0;
        if (acc_write) begin
            if (acc_block == 3'd7 && acc_reg == 8'h11) ptr = 0;
            else if (acc_block == 3'd7 && acc_reg == 8'h12) begin sram[ptr] = acc_wdata[7:0]; ptr++; end
            else if (acc_block == 3'd7 && acc_reg == 8'h05) dly_reg = acc_wdata;
            else if (acc_block == 3'd1 && acc_reg == 8'h19) pm_reg = acc_wdata;
        end else begin
            if (acc_block == 3'd7 && acc_reg == 8'h15) v = mbox_val;
            else if (acc_block == 3'd7 && acc_reg == 8'h18) v = ident_val;
            else if (acc_block == 3'd7 && acc_reg == 8'h05) v = cfg_bad ? (dly_reg & ~32'h2) : dly_reg;
            else if (acc_block == 3'd1 && acc_reg == 8'h19) v = pm_reg;
            else if (acc_block == 3'd7 && acc_reg == 8'h12) begin
                v = {24'd0, sram[ptr]};
                if (ptr < 16 && corrupt[ptr]) v = v ^ 32'h1;
                if (ptr == big_idx) v = v | 32'h100;
                ptr++;
            end
        end
        acc_rdata = v;
        acc_err   = (acc_n == err_on);
        acc_ack   = 1'b1;
    endtask

    // Device model and scoreboard monitor, away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            acc_ack = 1'b0; acc_err = 1'b0; lat = 0; acc_n = 0;
            rst_hi = 0; rst_at_id = -1; extra = 0; prev_req = 1'b0; ptr = 0;
        end else begin
            if (chip_rst) rst_hi++;
            if (acc_req && !prev_req) begin
                acc_n++;
                lat = 2;
                if (!acc_write && acc_block == 3'd7 && acc_reg == 8'h18) rst_at_id = rst_hi;
                if (exp_q.size() == 0) begin
                    extra++;
                    check("R11 unexpected access", 64'({acc_write, acc_block, acc_sub, acc_reg, acc_wdata}), 64'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(e.tag, 64'({acc_write, acc_block, acc_sub, acc_reg, acc_wdata}), 64'(e.acc));
                end
            end
            if (acc_ack) acc_ack = 1'b0;
            else if (acc_req) begin
                if (lat > 0) lat--;
                else respond();
            end
            prev_req = acc_req;
        end
    end

    task automatic push_detect();
        push("R2 mailbox read", 0, 7, 0, 8'h15, 0);
        push("R3 identity read", 0, 7, 0, 8'h18, 0);
    endtask

    task automatic push_upload();
        push("R4 halt", 1, 7, 0, 8'h10, 32'h8C);
        push("R4 pointer clear", 1, 7, 0, 8'h11, 0);
        for (int i = 0; i < LEN; i++) push("R5 upload byte", 1, 7, 0, 8'h12, {24'd0, ucode(i)});
        push("R6 pointer clear", 1, 7, 0, 8'h11, 0);
    endtask

    task automatic push_reads(int n);
        for (int i = 0; i < n; i++) push("R7 readback", 0, 7, 0, 8'h12, 0);
    endtask

    task automatic push_tail(bit full);
        push("R8 cpu start", 1, 7, 0, 8'h10, 32'h10B);
        push("R9 delay write", 1, 7, 0, 8'h05, 32'h33);
        push("R9 delay read", 0, 7, 0, 8'h05, 0);
        if (full) begin
            push("R9 port write", 1, 1, 6, 8'h19, 32'h2C);
            push("R9 port read", 0, 1, 6, 8'h19, 0);
            push("R10 mac hold", 1, 1, 6, 8'h00, 32'h2000_0030);
            push("R10 mac run", 1, 1, 6, 8'h00, 32'h1007_0184);
        end
    endtask

    task automatic reset_dut(logic [31:0] mb, logic [31:0] id);
        rst_n = 1'b0; start = 1'b0;
        mbox_val = mb; ident_val = id; corrupt = '0; big_idx = -1; err_on = -1; cfg_bad = 1'b0;
        exp_q.delete();
        repeat (3) @(negedge clk);
        check("R1 reset status", 64'({busy, done, fail, err_code, acc_req, chip_rst}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle without start", 64'({busy, acc_req}), 64'd0);
    endtask

    task automatic run_case(string name, bit exp_done, int exp_code);
        int cyc;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 0;
        while (!(done || fail) && cyc < 5000) begin @(negedge clk); cyc++; end
        if (cyc >= 5000) begin
            n_tests++; n_fail++;
            $display("FAIL R11 %s: watchdog, actual hung expected end", name);
        end
        repeat (30) @(negedge clk);
        check(exp_done ? "R10 done" : "R11 fail", 64'({done, fail}), exp_done ? 64'd2 : 64'd1);
        check("R11 error code", 64'(err_code), 64'(exp_code));
        check("R11 queue drained", 64'(exp_q.size()), 64'd0);
        check("R11 no extra access", 64'(extra), 64'd0);
    endtask

    initial begin
        // Normal bring-up: no reset pulse
        reset_dut(32'h0, 32'h1738_5ABC);
        push_detect(); push_upload(); push_reads(LEN); push_tail(1);
        run_case("normal", 1, 0);
        check("R2 no chip reset", 64'(rst_hi), 64'd0);

        // Mailbox all ones: reset pulse before identity read
        reset_dut(32'hFFFF_FFFF, 32'h0738_5000);
        push_detect(); push_upload(); push_reads(LEN); push_tail(1);
        run_case("mailbox ones", 1, 0);
        check("R2 pulse width before id read", 64'(rst_at_id), 64'(RSTC));

        // Wrong identity
        reset_dut(32'h0, 32'h1738_4ABC);
        push_detect();
        run_case("bad id", 0, 1);
        check("R3 no further access", 64'(acc_n), 64'd2);

        // Two mismatches: full read-back then verify failure
        reset_dut(32'h0, 32'h1738_5ABC);
        corrupt = 16'h0204;
        push_detect(); push_upload(); push_reads(LEN);
        run_case("two mismatches", 0, 3);

        // Every byte bad: stop after the fifth mismatch
        reset_dut(32'h0, 32'h1738_5ABC);
        corrupt = 16'hFFFF;
        push_detect(); push_upload(); push_reads(5);
        run_case("all mismatch", 0, 3);
        check("R7 reads stop at five", 64'(acc_n), 64'(4 + LEN + 1 + 5));

        // Oversized read value at index 3
        reset_dut(32'h0, 32'h1738_5ABC);
        big_idx = 3;
        push_detect(); push_upload(); push_reads(4);
        run_case("oversized value", 0, 3);
        check("R6 immediate stop", 64'(acc_n), 64'(4 + LEN + 1 + 4));

        // Clock-delay read-back misses a masked bit
        reset_dut(32'h0, 32'h1738_5ABC);
        cfg_bad = 1'b1;
        push_detect(); push_upload(); push_reads(LEN); push_tail(0);
        run_case("delay mismatch", 0, 4);

        // Access error on the first upload write
        reset_dut(32'h0, 32'h1738_5ABC);
        err_on = 5;
        push_detect();
        push("R4 halt", 1, 7, 0, 8'h10, 32'h8C);
        push("R4 pointer clear", 1, 7, 0, 8'h11, 0);
        push("R5 upload byte", 1, 7, 0, 8'h12, {24'd0, ucode(0)});
        run_case("upload access error", 0, 2);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule